// File: doc/BRIEF.md
# Video Memory Fetch Gap Arbiter

This block decides which of two masters owns an external video memory bus: a display fetch engine that streams pixel data as a series of read bursts, and a CPU/DMA master. The display engine has priority, but after it finishes a group of bursts the arbiter enforces an idle window on the display side. During that window the display engine cannot get the bus, and the CPU/DMA master may use it.

The window length comes from an 8-bit field held in the low byte of a 16-bit register. The window lasts one clock more than the programmed value. In normal mode a group is 16 bursts. In rotated mode a 2-bit select picks a group of 4, 8, 16 or 32 bursts. The arbiter counts burst-done strobes from the display engine while that engine holds the grant. When the last strobe of a group arrives, the arbiter starts the window and takes the grant away.

Top module: `vram_fetch_gap_arbiter`

## Requirements
- R1: After reset both grants are low, the interval field is 0x00 and `reg_rdata` reads 0x0000.
- R2: A write with `reg_wr_en` high stores `reg_wdata[7:0]` as the interval field. `reg_rdata` always shows the field in bits 7:0, and bits 15:8 always read 0 whatever was written to them.
- R3: In normal mode (`rot_mode` = 0) a group is exactly 16 burst-done strobes, whatever `rot_size_sel` holds.
- R4: After the last strobe of a group, `disp_gnt` stays low for exactly field+1 clocks (0x00 gives 1, 0xFF gives 256) while `disp_req` stays high and `host_req` stays low. It rises on the clock after that.
- R5: In rotated mode (`rot_mode` = 1) the group size is 4, 8, 16 or 32 bursts for `rot_size_sel` = 0, 1, 2 or 3.
- R6: `disp_gnt` is never high during the interval, even when `host_req` is low.
- R7: When `host_req` is high during the interval, `host_gnt` goes high on the next clock. `disp_gnt` and `host_gnt` are never high together.
- R8: Once `host_gnt` is high, it stays high for as long as `host_req` stays high, even after the interval ends. `disp_gnt` returns on the clock after `host_req` drops.
- R9: Outside the interval, when neither master owns the bus and both request in the same cycle, the display master is granted.
- R10: A register write made while an interval is counting does not change the length of that interval. It sets the length of the next interval.
- R11: The group size is taken at the start of a group, before its first strobe is counted. Changing `rot_size_sel` part way through a group only affects the next group.
- R12: A `disp_burst_done` strobe is counted only while `disp_gnt` is high. Strobes at other times do not move the group count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Write strobe for the interval register |
| reg_wdata | input | 16 | Register write data; only bits 7:0 are stored |
| reg_rdata | output | 16 | Register read value; bits 15:8 are zero |
| disp_req | input | 1 | Display fetch engine requests the bus |
| disp_gnt | output | 1 | Bus granted to the display fetch engine |
| disp_burst_done | input | 1 | One display read burst has completed |
| host_req | input | 1 | CPU/DMA master requests the bus |
| host_gnt | output | 1 | Bus granted to the CPU/DMA master |
| rot_mode | input | 1 | 1 selects rotated-image group sizing |
| rot_size_sel | input | 2 | Rotated group size: 0=4, 1=8, 2=16, 3=32 bursts |

## Verification
The bound checker verifies on every cycle that the two grants never overlap, that the display grant stays low while the interval is active, that a held host grant is not taken away, that the reserved read bits stay zero, and that an interval only starts right after a granted burst-done strobe. Other behaviours can only be shown by the bench scenarios: the exact burst count per group for each mode and select value, the exact window length including the 256-clock extreme, the deferred effect of a write made during a window, the latching of the group size at a boundary, and ignored strobes while the display engine is not granted.

// File: rtl/fga_pkg.sv
package fga_pkg;
    typedef enum logic [1:0] {
        OWN_IDLE = 2'd0,
        OWN_DISP = 2'd1,
        OWN_HOST = 2'd2
    } owner_e;
endpackage

// File: rtl/fga_intv_reg.sv
module fga_intv_reg #(
    parameter int DATA_W = 16,
    parameter int INTV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [INTV_W-1:0] field_q,
    output logic [DATA_W-1:0] rdata
);
    localparam int RSVD_W = DATA_W - INTV_W;

    typedef struct packed {
        logic [INTV_W-1:0] field;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic       rsvd_unused;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.field = wdata[INTV_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsvd_unused = ^wdata[DATA_W-1:INTV_W];
    assign field_q     = st_q.field;
    assign rdata       = {{RSVD_W{1'b0}}, st_q.field};
endmodule

// File: rtl/fga_group_ctr.sv
module fga_group_ctr #(
    parameter int GRP_W        = 6,
    parameter int NORMAL_GROUP = 16,
    parameter int ROT_BASE     = 4,
    parameter int SEL_W        = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             rot_mode,
    input  logic [SEL_W-1:0] size_sel,
    output logic             group_end
);
    typedef struct packed {
        logic [GRP_W-1:0] cnt;
        logic [GRP_W-1:0] size;
    } grp_state_t;

    grp_state_t       st_d, st_q;
    logic [GRP_W-1:0] size_req;
    logic             last_burst;

    always_comb begin
        if (rot_mode) begin
            size_req = GRP_W'(ROT_BASE) << size_sel;
        end else begin
            size_req = GRP_W'(NORMAL_GROUP);
        end
    end

    always_comb begin
        st_d       = st_q;
        last_burst = (st_q.cnt == (st_q.size - GRP_W'(1)));
        if (st_q.cnt == '0) begin
            st_d.size = size_req;
        end
        if (count_en) begin
            if (last_burst) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + GRP_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.size <= GRP_W'(NORMAL_GROUP);
        end else begin
            st_q <= st_d;
        end
    end

    assign group_end = count_en && last_burst;
endmodule

// File: rtl/fga_gap_ctr.sv
module fga_gap_ctr #(
    parameter int INTV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [INTV_W-1:0] intv,
    output logic              gap_busy,
    output logic              gap_busy_next
);
    localparam int GAP_W = INTV_W + 1;

    typedef struct packed {
        logic [GAP_W-1:0] cnt;
    } gap_state_t;

    gap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = {1'b0, intv} + GAP_W'(1);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - GAP_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gap_busy      = (st_q.cnt != '0);
    assign gap_busy_next = (st_d.cnt != '0);
endmodule

// File: rtl/fga_grant.sv
module fga_grant
    import fga_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gap_busy_next,
    input  logic disp_req,
    input  logic host_req,
    output logic disp_gnt,
    output logic host_gnt
);
    typedef struct packed {
        owner_e owner;
    } gnt_state_t;

    gnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (gap_busy_next) begin
            st_d.owner = host_req ? OWN_HOST : OWN_IDLE;
        end else if (st_q.owner == OWN_HOST && host_req) begin
            st_d.owner = OWN_HOST;
        end else if (disp_req) begin
            st_d.owner = OWN_DISP;
        end else if (host_req) begin
            st_d.owner = OWN_HOST;
        end else begin
            st_d.owner = OWN_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.owner <= OWN_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign disp_gnt = (st_q.owner == OWN_DISP);
    assign host_gnt = (st_q.owner == OWN_HOST);
endmodule

// File: rtl/vram_fetch_gap_arbiter.sv
module vram_fetch_gap_arbiter #(
    parameter int DATA_W       = 16,
    parameter int INTV_W       = 8,
    parameter int GRP_W        = 6,
    parameter int NORMAL_GROUP = 16,
    parameter int ROT_BASE     = 4,
    parameter int SEL_W        = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              disp_req,
    output logic              disp_gnt,
    input  logic              disp_burst_done,
    input  logic              host_req,
    output logic              host_gnt,
    input  logic              rot_mode,
    input  logic [SEL_W-1:0]  rot_size_sel
);
    logic [INTV_W-1:0] intv_field;
    logic              burst_cnt_en;
    logic              group_end;
    logic              gap_busy;
    logic              gap_busy_next;

    fga_intv_reg #(
        .DATA_W (DATA_W),
        .INTV_W (INTV_W)
    ) u_intv_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wdata   (reg_wdata),
        .field_q (intv_field),
        .rdata   (reg_rdata)
    );

    assign burst_cnt_en = disp_burst_done && disp_gnt;

    fga_group_ctr #(
        .GRP_W        (GRP_W),
        .NORMAL_GROUP (NORMAL_GROUP),
        .ROT_BASE     (ROT_BASE),
        .SEL_W        (SEL_W)
    ) u_group_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_en  (burst_cnt_en),
        .rot_mode  (rot_mode),
        .size_sel  (rot_size_sel),
        .group_end (group_end)
    );

    fga_gap_ctr #(
        .INTV_W (INTV_W)
    ) u_gap_ctr (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (group_end),
        .intv          (intv_field),
        .gap_busy      (gap_busy),
        .gap_busy_next (gap_busy_next)
    );

    fga_grant u_grant (
        .clk           (clk),
        .rst_n         (rst_n),
        .gap_busy_next (gap_busy_next),
        .disp_req      (disp_req),
        .host_req      (host_req),
        .disp_gnt      (disp_gnt),
        .host_gnt      (host_gnt)
    );
endmodule

// File: rtl/vram_fetch_gap_arbiter_chk.sv
module vram_fetch_gap_arbiter_chk #(
    parameter int DATA_W = 16,
    parameter int INTV_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              disp_gnt,
    input logic              host_gnt,
    input logic              host_req,
    input logic              disp_burst_done,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              gap_busy
);
    AST_GNT_MUTEX: assert property (@(posedge clk) disable iff (!rst_n)
        !(disp_gnt && host_gnt)); // R7

    AST_NO_DISP_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        gap_busy |-> !disp_gnt); // R6

    AST_HOST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (host_gnt && host_req) |=> host_gnt); // R8

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:INTV_W] == '0); // R2

    AST_GAP_AFTER_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gap_busy) |-> $past(disp_burst_done && disp_gnt)); // R12
endmodule

bind vram_fetch_gap_arbiter vram_fetch_gap_arbiter_chk #(
    .DATA_W (DATA_W),
    .INTV_W (INTV_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .disp_gnt        (disp_gnt),
    .host_gnt        (host_gnt),
    .host_req        (host_req),
    .disp_burst_done (disp_burst_done),
    .reg_rdata       (reg_rdata),
    .gap_busy        (gap_busy)
);

// File: tb/vram_fetch_gap_arbiter_tb_top.sv
module vram_fetch_gap_arbiter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    typedef struct packed {
        logic       rot;
        logic [1:0] sel;
        logic [7:0] intv;
        int         nb;
        int         gap;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 2'd0, 8'h00, 16,   1},
        '{1'b0, 2'd3, 8'h01, 16,   2},
        '{1'b1, 2'd0, 8'h03, 4,    4},
        '{1'b1, 2'd1, 8'hFF, 8,  256},
        '{1'b1, 2'd2, 8'h07, 16,   8},
        '{1'b1, 2'd3, 8'h02, 32,   3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        disp_req = 1'b0;
    logic        disp_gnt;
    logic        disp_burst_done = 1'b0;
    logic        host_req = 1'b0;
    logic        host_gnt;
    logic        rot_mode = 1'b0;
    logic [1:0]  rot_size_sel = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vram_fetch_gap_arbiter dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .reg_wr_en       (reg_wr_en),
        .reg_wdata       (reg_wdata),
        .reg_rdata       (reg_rdata),
        .disp_req        (disp_req),
        .disp_gnt        (disp_gnt),
        .disp_burst_done (disp_burst_done),
        .host_req        (host_req),
        .host_gnt        (host_gnt),
        .rot_mode        (rot_mode),
        .rot_size_sel    (rot_size_sel)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [15:0] v);
        reg_wr_en = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
        reg_wdata = '0;
        @(negedge clk);
    endtask

    // Runs one burst group with disp_req held high and counts strobes and gap clocks.
    task automatic run_group(input string tag, input int exp_b, input int exp_g,
                             input bit do_wr, input logic [7:0] wv,
                             input int chg_at, input logic [1:0] nsel);
        int nb;
        int ng;
        int guard;
        nb = 0;
        ng = 0;
        guard = 0;
        disp_req = 1'b1;
        while (!disp_gnt && guard < 2000) begin
            guard++;
            @(negedge clk);
        end
        while (disp_gnt && nb < 100) begin
            if (nb == chg_at) rot_size_sel = nsel;
            disp_burst_done = 1'b1;
            nb++;
            @(negedge clk);
            disp_burst_done = 1'b0;
        end
        while (!disp_gnt && ng < 1000) begin
            if (do_wr && ng == 0) begin
                reg_wr_en = 1'b1;
                reg_wdata = {8'h00, wv};
            end else begin
                reg_wr_en = 1'b0;
            end
            ng++;
            @(negedge clk);
        end
        reg_wr_en = 1'b0;
        check({tag, " bursts per group"}, nb, exp_b);
        check({tag, " gap clocks"}, ng, exp_g);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 disp_gnt after reset", int'(disp_gnt), 0);
        check("R1 host_gnt after reset", int'(host_gnt), 0);
        check("R1 reg_rdata after reset", int'(reg_rdata), 0);

        // R2: reserved upper byte ignored
        reg_write(16'hAB5C);
        check("R2 readback of field", int'(reg_rdata), 32'h005C);

        // R3 R4 R5 R6: vector table (host idle throughout)
        for (int i = 0; i < NVEC; i++) begin
            rot_mode     = VECS[i].rot;
            rot_size_sel = VECS[i].sel;
            reg_write({8'hFF, VECS[i].intv});
            check("R2 table readback", int'(reg_rdata), int'(VECS[i].intv));
            run_group($sformatf("R3/R5/R4/R6 vec%0d", i), VECS[i].nb, VECS[i].gap,
                      1'b0, 8'h00, -1, VECS[i].sel);
        end

        // R10: write during a counting interval
        rot_mode = 1'b0;
        reg_write(16'h0009);
        run_group("R10 current gap", 16, 10, 1'b1, 8'h02, -1, 2'd0);
        check("R10 new field readback", int'(reg_rdata), 2);
        run_group("R10 next gap", 16, 3, 1'b0, 8'h00, -1, 2'd0);

        // R11: size change mid-group deferred
        rot_mode     = 1'b1;
        rot_size_sel = 2'd0;
        reg_write(16'h0000);
        run_group("R11 group with mid change", 4, 1, 1'b0, 8'h00, 2, 2'd3);
        run_group("R11 following group", 32, 1, 1'b0, 8'h00, -1, 2'd3);

        // R6 R7 R8: host during and beyond the interval
        begin
            int bad;
            int nb;
            bad = 0;
            nb  = 0;
            rot_mode = 1'b0;
            reg_write(16'h0005);
            while (disp_gnt && nb < 100) begin
                disp_burst_done = 1'b1;
                nb++;
                @(negedge clk);
                disp_burst_done = 1'b0;
            end
            check("R3 host scenario bursts", nb, 16);
            host_req = 1'b1;
            @(negedge clk);
            check("R7 host_gnt in gap", int'(host_gnt), 1);
            check("R7 disp_gnt in gap", int'(disp_gnt), 0);
            for (int k = 0; k < 12; k++) begin
                if (disp_gnt || !host_gnt) bad++;
                @(negedge clk);
            end
            check("R8 host held past gap", bad, 0);
            host_req = 1'b0;
            @(negedge clk);
            check("R8 disp regranted after host", int'(disp_gnt), 1);
            check("R8 host released", int'(host_gnt), 0);
        end

        // R9: simultaneous requests from idle
        disp_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R9 idle before race", int'(disp_gnt | host_gnt), 0);
        disp_req = 1'b1;
        host_req = 1'b1;
        @(negedge clk);
        check("R9 display wins", int'(disp_gnt), 1);
        check("R9 host waits", int'(host_gnt), 0);
        disp_req = 1'b0;
        @(negedge clk);
        check("R9 host after display leaves", int'(host_gnt), 1);
        host_req = 1'b0;
        @(negedge clk);

        // R12: strobes while not granted are ignored
        rot_mode     = 1'b1;
        rot_size_sel = 2'd0;
        reg_write(16'h0001);
        for (int k = 0; k < 20; k++) begin
            disp_burst_done = 1'b1;
            @(negedge clk);
        end
        disp_burst_done = 1'b0;
        check("R12 no grant from stray strobes", int'(disp_gnt), 0);
        run_group("R12 group after stray strobes", 4, 2, 1'b0, 8'h00, -1, 2'd0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule